// File: doc/BRIEF.md
# Enhanced Parallel Port Transfer Gate

This block is the host-facing path for the enhanced parallel port's address and data cycles. A host access to the address port or the data port becomes a request to a downstream byte handshake engine. The request is issued only when the stored control register holds the exact bit pattern for that direction of transfer. Any other access is dropped. A dropped read returns all ones.

The block also owns the control register and a sticky timeout flag. The flag is set when the downstream engine reports an error. It shows in bit 0 of the status register and is cleared by writing 1 to that bit. Data-port accesses may be 1, 2 or 4 bytes wide and are split into single-byte transfers, least significant byte first. A wide access stops at the first failing byte.

The host presents one access at a time. It holds `h_valid_i` until the block accepts it while `h_ready_o` is high. The block then holds `h_ready_o` low until it has pulsed `h_resp_o` with the read data.

Top module: `epp_access_path`

## Requirements
- R1: After reset, `h_ready_o` is 1, `ctrl_o` is 0xCC, the timeout flag is 0, and neither `ds_req_o` nor `dir_chg_o` is asserted.
- R2: An address-port (offset 3) or data-port (offset 4) write issues downstream bytes only when the control bits [5,3,2,1,0] are exactly 0,0,1,0,0. Otherwise no byte is requested and the access completes with no effect.
- R3: An address-port or data-port read issues downstream bytes only when the control bits [5,3,2,1,0] are exactly 1,0,1,0,0. Otherwise no byte is requested, and the read returns ones in every byte lane of the access width and zero in the lanes above it.
- R4: A downstream byte that completes with `ds_err_i` high sets the timeout flag. The flag stays set through later successful transfers.
- R5: A status write (offset 1) with data bit 0 set clears the timeout flag. A status write with bit 0 clear leaves the flag unchanged.
- R6: A status read returns `port_status_i[7:1]` in bits 7:1 and the timeout flag in bit 0.
- R7: `h_size_i` selects the data-port width: 0 means 1 byte, 1 means 2 bytes, 2 or 3 means 4 bytes. Bytes are transferred from lane 0 upward. Address-port accesses always move one byte.
- R8: A wide access stops at the first byte that reports an error. Read lanes that were not transferred without error return 0xFF.
- R9: A control write (offset 2) that changes bit 5 pulses `dir_chg_o` for one cycle, with `dir_val_o` carrying the new bit 5, while `ctrl_o` still holds the old value. The new value appears in the following cycle.
- R10: A control write stores data bits 5:0 with bits 7:6 forced to 1. A control read returns the stored value.
- R11: After an access is accepted, `h_ready_o` stays low until the cycle after the one-cycle `h_resp_o` pulse. Write responses carry zero data. Reads at offsets 0, 5, 6 and 7 return 0x000000FF, and writes there have no effect.
- R12: `ds_req_o` stays high until `ds_done_i` and then falls for at least one cycle before the next byte. `ds_addr_o` is 1 for address-port cycles, and `ds_rd_o` is 1 for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_valid_i | input | 1 | Host access request |
| h_write_i | input | 1 | 1 = write, 0 = read |
| h_offs_i | input | 3 | Register offset |
| h_size_i | input | 2 | Access width code for the data port |
| h_wdata_i | input | 32 | Host write data, lane 0 in bits 7:0 |
| h_ready_o | output | 1 | Block can accept an access |
| h_resp_o | output | 1 | One-cycle completion pulse |
| h_rdata_o | output | 32 | Read data, valid with `h_resp_o` |
| port_status_i | input | 8 | Sampled port status lines |
| ctrl_o | output | 8 | Stored control register |
| dir_chg_o | output | 1 | Direction-change pulse |
| dir_val_o | output | 1 | New direction value |
| ds_req_o | output | 1 | Downstream byte request |
| ds_addr_o | output | 1 | 1 = address cycle, 0 = data cycle |
| ds_rd_o | output | 1 | 1 = read byte, 0 = write byte |
| ds_wdata_o | output | 8 | Byte to write |
| ds_done_i | input | 1 | Byte complete |
| ds_err_i | input | 1 | Byte failed, valid with `ds_done_i` |
| ds_rdata_i | input | 8 | Byte read, valid with `ds_done_i` |

## Verification
If the control register or the gate decode is wrong, the fault shows up on the very next address-port or data-port access. Either a byte request appears where none may, or a permitted transfer is silently dropped and returns all ones. A corrupted byte index or count shows within the same access: the lanes arrive in the wrong order, or too many or too few requests are issued. A lost or stuck timeout flag is hidden until the next status read, so the sequence reads status right after every error and after every clear.

// File: rtl/epp_pkg.sv
package epp_pkg;
  localparam int unsigned CTL_W   = 8;
  localparam int unsigned BIT_DIR = 5;
  localparam logic [CTL_W-1:0] GATE_MASK  = 8'h2F;
  localparam logic [CTL_W-1:0] WR_PATTERN = 8'h04;
  localparam logic [CTL_W-1:0] RD_PATTERN = 8'h24;
  localparam logic [CTL_W-1:0] CTL_FIXED  = 8'hC0;

  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_GAP} seq_state_t;
  typedef enum logic [1:0] {TP_IDLE, TP_DIR, TP_XFER, TP_RESP} top_state_t;

  function automatic int unsigned width_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/epp_cycle_gate.sv
module epp_cycle_gate
  import epp_pkg::*;
#(
  parameter logic [CTL_W-1:0] MASK   = GATE_MASK,
  parameter logic [CTL_W-1:0] WR_PAT = WR_PATTERN,
  parameter logic [CTL_W-1:0] RD_PAT = RD_PATTERN
) (
  input  logic [CTL_W-1:0] ctrl_i,
  output logic             wr_ok_o,
  output logic             rd_ok_o
);
  logic [CTL_W-1:0] masked;
  assign masked  = ctrl_i & MASK;
  assign wr_ok_o = (masked == WR_PAT);
  assign rd_ok_o = (masked == RD_PAT);
endmodule

// File: rtl/epp_sticky_flag.sv
module epp_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R4
  tmo_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  // R5
  tmo_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/epp_byte_seq.sv
module epp_byte_seq
  import epp_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned HW    = BYTE_W * LANES,
  localparam int unsigned CNT_W = $clog2(LANES + 1),
  localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic              addr_sel_i,
  input  logic [CNT_W-1:0]  nbytes_i,
  input  logic [HW-1:0]     wdata_i,
  input  logic [CTL_W-1:0]  ctrl_i,
  output logic              ds_req_o,
  output logic              ds_addr_o,
  output logic              ds_rd_o,
  output logic [BYTE_W-1:0] ds_wdata_o,
  input  logic              ds_done_i,
  input  logic              ds_err_i,
  input  logic [BYTE_W-1:0] ds_rdata_i,
  output logic              fin_o,
  output logic              err_o,
  output logic [HW-1:0]     rdata_o
);
  seq_state_t         st;
  logic [CNT_W-1:0]   idx;
  logic [CNT_W-1:0]   n_q;
  logic               rd_q;
  logic               asel_q;
  logic [HW-1:0]      wbuf;
  logic [BYTE_W-1:0]  lane_w [LANES];
  logic               last_byte;

  assign last_byte  = ((idx + CNT_W'(1)) == n_q);
  assign ds_req_o   = (st == SQ_REQ);
  assign ds_addr_o  = asel_q;
  assign ds_rd_o    = rd_q;
  assign ds_wdata_o = lane_w[idx[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SQ_IDLE;
      idx    <= '0;
      n_q    <= '0;
      rd_q   <= 1'b0;
      asel_q <= 1'b0;
      wbuf   <= '0;
      fin_o  <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (start_i) begin
            st     <= SQ_REQ;
            idx    <= '0;
            n_q    <= nbytes_i;
            rd_q   <= rd_i;
            asel_q <= addr_sel_i;
            wbuf   <= wdata_i;
            err_o  <= 1'b0;
          end
        end
        SQ_REQ: begin
          if (ds_done_i) begin
            if (ds_err_i) begin
              err_o <= 1'b1;
              fin_o <= 1'b1;
              st    <= SQ_IDLE;
            end else if (last_byte) begin
              fin_o <= 1'b1;
              st    <= SQ_IDLE;
            end else begin
              idx <= idx + CNT_W'(1);
              st  <= SQ_GAP;
            end
          end
        end
        SQ_GAP:  st <= SQ_REQ;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_w[g] = wbuf[g*BYTE_W +: BYTE_W];
    always_ff @(posedge clk) begin
      if (rst)
        rdata_o[g*BYTE_W +: BYTE_W] <= '0;
      else if (st == SQ_IDLE && start_i)
        rdata_o[g*BYTE_W +: BYTE_W] <= (CNT_W'(g) < nbytes_i) ? {BYTE_W{1'b1}} : {BYTE_W{1'b0}};
      else if (st == SQ_REQ && ds_done_i && !ds_err_i && idx == CNT_W'(g))
        rdata_o[g*BYTE_W +: BYTE_W] <= ds_rdata_i;
    end
  end

  // R12
  ds_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ds_req_o && !ds_done_i) |=> ds_req_o);
  // R12
  ds_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (ds_req_o && ds_done_i) |=> !ds_req_o);
  // R2
  wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (ds_req_o && !ds_rd_o) |-> ((ctrl_i & GATE_MASK) == WR_PATTERN));
  // R3
  rd_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (ds_req_o && ds_rd_o) |-> ((ctrl_i & GATE_MASK) == RD_PATTERN));
  // R7
  lane_range_chk: assert property (@(posedge clk) disable iff (rst)
    ds_req_o |-> (idx < n_q));
endmodule

// File: rtl/epp_access_path.sv
module epp_access_path
  import epp_pkg::*;
#(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned LANES      = 4,
  parameter int unsigned OFFS_W     = 3,
  parameter int unsigned STS_OFFS   = 1,
  parameter int unsigned CTL_OFFS   = 2,
  parameter int unsigned APORT_OFFS = 3,
  parameter int unsigned DPORT_OFFS = 4,
  parameter logic [7:0]  CTL_RESET  = 8'hCC,
  localparam int unsigned HW    = BYTE_W * LANES,
  localparam int unsigned CNT_W = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_valid_i,
  input  logic              h_write_i,
  input  logic [OFFS_W-1:0] h_offs_i,
  input  logic [1:0]        h_size_i,
  input  logic [HW-1:0]     h_wdata_i,
  output logic              h_ready_o,
  output logic              h_resp_o,
  output logic [HW-1:0]     h_rdata_o,
  input  logic [7:0]        port_status_i,
  output logic [7:0]        ctrl_o,
  output logic              dir_chg_o,
  output logic              dir_val_o,
  output logic              ds_req_o,
  output logic              ds_addr_o,
  output logic              ds_rd_o,
  output logic [BYTE_W-1:0] ds_wdata_o,
  input  logic              ds_done_i,
  input  logic              ds_err_i,
  input  logic [BYTE_W-1:0] ds_rdata_i
);
  top_state_t       st;
  logic             accept;
  logic             is_sts, is_ctl, is_ap, is_dp;
  logic             wr_ok, rd_ok, xfer_ok, seq_start;
  logic [CNT_W-1:0] nb;
  logic [7:0]       new_ctl;
  logic [7:0]       pend_ctl;
  logic [HW-1:0]    rd_value;
  logic             op_rd_q;
  logic             tmo, tmo_set, tmo_clr;
  logic             seq_fin, seq_err;
  logic [HW-1:0]    seq_rdata;
  logic             unused_sts;

  assign unused_sts = port_status_i[0];
  assign accept  = h_valid_i && h_ready_o;
  assign is_sts  = (h_offs_i == OFFS_W'(STS_OFFS));
  assign is_ctl  = (h_offs_i == OFFS_W'(CTL_OFFS));
  assign is_ap   = (h_offs_i == OFFS_W'(APORT_OFFS));
  assign is_dp   = (h_offs_i == OFFS_W'(DPORT_OFFS));
  assign new_ctl = CTL_FIXED | {2'b00, h_wdata_i[5:0]};

  always_comb begin
    int unsigned full;
    full = is_dp ? width_bytes(h_size_i) : 1;
    if (full > LANES) full = LANES;
    nb = CNT_W'(full);
  end

  epp_cycle_gate u_gate (
    .ctrl_i  (ctrl_o),
    .wr_ok_o (wr_ok),
    .rd_ok_o (rd_ok)
  );

  assign xfer_ok   = (is_ap || is_dp) && (h_write_i ? wr_ok : rd_ok);
  assign seq_start = accept && xfer_ok;

  always_comb begin
    rd_value = '0;
    if (!h_write_i) begin
      if (is_sts) begin
        rd_value[7:0] = {port_status_i[7:1], tmo};
      end else if (is_ctl) begin
        rd_value[7:0] = ctrl_o;
      end else if (is_ap || is_dp) begin
        for (int k = 0; k < LANES; k++)
          if (CNT_W'(k) < nb) rd_value[k*BYTE_W +: BYTE_W] = {BYTE_W{1'b1}};
      end else begin
        rd_value[7:0] = 8'hFF;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= TP_IDLE;
      h_ready_o <= 1'b1;
      h_resp_o  <= 1'b0;
      h_rdata_o <= '0;
      ctrl_o    <= CTL_RESET;
      pend_ctl  <= CTL_RESET;
      dir_chg_o <= 1'b0;
      dir_val_o <= CTL_RESET[BIT_DIR];
      op_rd_q   <= 1'b0;
    end else begin
      h_resp_o  <= 1'b0;
      dir_chg_o <= 1'b0;
      case (st)
        TP_IDLE: begin
          if (accept) begin
            h_ready_o <= 1'b0;
            op_rd_q   <= !h_write_i;
            if (seq_start) begin
              st <= TP_XFER;
            end else if (h_write_i && is_ctl && (new_ctl[BIT_DIR] != ctrl_o[BIT_DIR])) begin
              st        <= TP_DIR;
              dir_chg_o <= 1'b1;
              dir_val_o <= new_ctl[BIT_DIR];
              pend_ctl  <= new_ctl;
            end else begin
              st        <= TP_RESP;
              h_resp_o  <= 1'b1;
              h_rdata_o <= rd_value;
              if (h_write_i && is_ctl) ctrl_o <= new_ctl;
            end
          end
        end
        TP_DIR: begin
          ctrl_o    <= pend_ctl;
          st        <= TP_RESP;
          h_resp_o  <= 1'b1;
          h_rdata_o <= '0;
        end
        TP_XFER: begin
          if (seq_fin) begin
            st        <= TP_RESP;
            h_resp_o  <= 1'b1;
            h_rdata_o <= op_rd_q ? seq_rdata : '0;
          end
        end
        TP_RESP: begin
          st        <= TP_IDLE;
          h_ready_o <= 1'b1;
        end
        default: st <= TP_IDLE;
      endcase
    end
  end

  epp_byte_seq #(.BYTE_W(BYTE_W), .LANES(LANES)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (seq_start),
    .rd_i       (!h_write_i),
    .addr_sel_i (is_ap),
    .nbytes_i   (nb),
    .wdata_i    (h_wdata_i),
    .ctrl_i     (ctrl_o),
    .ds_req_o   (ds_req_o),
    .ds_addr_o  (ds_addr_o),
    .ds_rd_o    (ds_rd_o),
    .ds_wdata_o (ds_wdata_o),
    .ds_done_i  (ds_done_i),
    .ds_err_i   (ds_err_i),
    .ds_rdata_i (ds_rdata_i),
    .fin_o      (seq_fin),
    .err_o      (seq_err),
    .rdata_o    (seq_rdata)
  );

  assign tmo_set = ds_req_o && ds_done_i && ds_err_i;
  assign tmo_clr = accept && h_write_i && is_sts && h_wdata_i[0];

  epp_sticky_flag u_tmo (
    .clk    (clk),
    .rst    (rst),
    .set_i  (tmo_set),
    .clr_i  (tmo_clr),
    .flag_o (tmo)
  );

  // R9
  dir_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dir_chg_o |-> (dir_val_o != ctrl_o[BIT_DIR]));
  // R9
  dir_apply_chk: assert property (@(posedge clk) disable iff (rst)
    dir_chg_o |=> (ctrl_o[BIT_DIR] == $past(dir_val_o)));
  // R11
  resp_busy_chk: assert property (@(posedge clk) disable iff (rst)
    h_resp_o |-> !h_ready_o);
  // R11
  resp_release_chk: assert property (@(posedge clk) disable iff (rst)
    h_resp_o |=> h_ready_o);
  // R10
  ctl_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_o[7:6] == 2'b11);
  // R8
  err_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_fin && seq_err) |-> !ds_req_o);
endmodule

// File: tb/tb_epp_access_path.sv
`timescale 1ns/1ps
module tb_epp_access_path;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_valid = 1'b0, h_write = 1'b0;
  logic [2:0]  h_offs = '0;
  logic [1:0]  h_size = '0;
  logic [31:0] h_wdata = '0;
  logic        h_ready_o, h_resp_o;
  logic [31:0] h_rdata_o;
  logic [7:0]  port_status = 8'hA5;
  logic [7:0]  ctrl_o;
  logic        dir_chg_o, dir_val_o;
  logic        ds_req_o, ds_addr_o, ds_rd_o;
  logic [7:0]  ds_wdata_o;
  logic        ds_done = 1'b0, ds_err = 1'b0;
  logic [7:0]  ds_rdata = '0;

  int nchk = 0, nfail = 0;
  logic [7:0]  m_ctl = 8'hCC;
  logic        m_tmo = 1'b0;
  int          err_byte = -1;
  logic [31:0] rd_src = '0;
  int          acc_bytes = 0, rsp_cnt = 0;
  logic        lg_asel [4];
  logic        lg_rd   [4];
  logic [7:0]  lg_wd   [4];
  int          dir_pulses = 0;
  logic [7:0]  dir_ctl_seen = '0;
  logic        dir_v_seen = 1'b0;

  always #2.5 clk = ~clk;

  epp_access_path dut (
    .clk(clk), .rst(rst), .h_valid_i(h_valid), .h_write_i(h_write),
    .h_offs_i(h_offs), .h_size_i(h_size), .h_wdata_i(h_wdata),
    .h_ready_o(h_ready_o), .h_resp_o(h_resp_o), .h_rdata_o(h_rdata_o),
    .port_status_i(port_status), .ctrl_o(ctrl_o), .dir_chg_o(dir_chg_o),
    .dir_val_o(dir_val_o), .ds_req_o(ds_req_o), .ds_addr_o(ds_addr_o),
    .ds_rd_o(ds_rd_o), .ds_wdata_o(ds_wdata_o), .ds_done_i(ds_done),
    .ds_err_i(ds_err), .ds_rdata_i(ds_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // downstream responder: latency 1..3 cycles per byte, optional error
  always @(negedge clk) begin
    if (ds_done) begin
      ds_done = 1'b0;
      ds_err  = 1'b0;
    end else if (ds_req_o) begin
      rsp_cnt++;
      if (rsp_cnt >= 1 + (acc_bytes % 3) && acc_bytes < 4) begin
        ds_done  = 1'b1;
        ds_err   = (acc_bytes == err_byte);
        ds_rdata = rd_src[8*acc_bytes +: 8];
        lg_asel[acc_bytes] = ds_addr_o;
        lg_rd[acc_bytes]   = ds_rd_o;
        lg_wd[acc_bytes]   = ds_wdata_o;
        acc_bytes++;
        rsp_cnt = 0;
      end
    end else begin
      rsp_cnt = 0;
    end
  end

  // per-clock comparison of idle-state outputs against the model
  always @(posedge clk) begin
    #1;
    if (!rst) begin
      if (dir_chg_o) begin
        dir_pulses++;
        dir_ctl_seen = ctrl_o;
        dir_v_seen   = dir_val_o;
      end
      if (h_ready_o) begin
        chk(ctrl_o == m_ctl, "R10 idle control", {24'h0, ctrl_o}, {24'h0, m_ctl});
        chk(!ds_req_o && !dir_chg_o, "R12 idle quiet", {30'h0, ds_req_o, dir_chg_o}, 32'h0);
      end
    end
  end

  function automatic int nb_of(input logic [2:0] offs, input logic [1:0] sz);
    if (offs != 3'd4) return 1;
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  task automatic xfer(input bit wr, input logic [2:0] offs, input logic [1:0] sz,
                      input logic [31:0] wd, input string tag);
    int waitc, n, nexp;
    bit allowed, errhit;
    logic [31:0] exp_rd, got;
    logic [7:0] gated;
    gated   = m_ctl & 8'h2F;
    allowed = (offs == 3'd3 || offs == 3'd4) && (wr ? (gated == 8'h04) : (gated == 8'h24));
    n       = nb_of(offs, sz);
    errhit  = allowed && err_byte >= 0 && err_byte < n;
    nexp    = !allowed ? 0 : (errhit ? err_byte + 1 : n);
    exp_rd  = '0;
    if (!wr) begin
      if (offs == 3'd1)      exp_rd = {24'h0, port_status[7:1], m_tmo};
      else if (offs == 3'd2) exp_rd = {24'h0, m_ctl};
      else if (offs == 3'd3 || offs == 3'd4) begin
        for (int k = 0; k < n; k++)
          exp_rd[8*k +: 8] = (allowed && (!errhit || k < err_byte)) ? rd_src[8*k +: 8] : 8'hFF;
      end else exp_rd = 32'h0000_00FF;
    end
    acc_bytes = 0;
    h_valid = 1'b1; h_write = wr; h_offs = offs; h_size = sz; h_wdata = wd;
    @(negedge clk);
    h_valid = 1'b0;
    waitc = 0;
    while (!h_resp_o && waitc < 200) begin @(negedge clk); waitc++; end
    got = h_rdata_o;
    chk(h_resp_o && !h_ready_o, {tag, " R11 resp"}, {30'h0, h_resp_o, h_ready_o}, 32'h2);
    if (wr && offs == 3'd2) m_ctl = 8'hC0 | {2'b00, wd[5:0]};
    if (wr && offs == 3'd1 && wd[0]) m_tmo = 1'b0;
    if (errhit) m_tmo = 1'b1;
    chk(got == exp_rd, {tag, " rdata"}, got, exp_rd);
    chk(acc_bytes == nexp, {tag, " byte count"}, acc_bytes, nexp);
    for (int k = 0; k < nexp && k < acc_bytes; k++) begin
      chk(lg_asel[k] == (offs == 3'd3) && lg_rd[k] == !wr, {tag, " R12 kind"},
          {30'h0, lg_asel[k], lg_rd[k]}, {30'h0, offs == 3'd3, !wr});
      if (wr) chk(lg_wd[k] == wd[8*k +: 8], {tag, " R7 lane order"}, lg_wd[k], wd[8*k +: 8]);
    end
    @(negedge clk);
    chk(h_ready_o, {tag, " R11 ready back"}, h_ready_o, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int p0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(h_ready_o && !ds_req_o && !dir_chg_o && ctrl_o == 8'hCC, "R1 reset outputs",
        {h_ready_o, ds_req_o, dir_chg_o, 21'h0, ctrl_o}, {3'b100, 21'h0, 8'hCC});
    xfer(0, 3'd1, 2'd0, 0, "R1 R6 status after reset");
    // R2/R3 blocked in reset control pattern
    xfer(1, 3'd3, 2'd0, 32'h5A, "R2 blocked addr write");
    xfer(1, 3'd4, 2'd2, 32'hCAFEF00D, "R2 blocked data write");
    xfer(0, 3'd4, 2'd1, 0, "R3 blocked read 2B");
    xfer(0, 3'd4, 2'd2, 0, "R3 blocked read 4B");
    xfer(0, 3'd3, 2'd0, 0, "R3 blocked addr read");
    // R10 control and write pattern
    xfer(1, 3'd2, 2'd0, 32'h04, "R10 ctl write");
    xfer(0, 3'd2, 2'd0, 0, "R10 ctl read");
    xfer(1, 3'd3, 2'd0, 32'h5A, "R2 addr write");
    xfer(1, 3'd4, 2'd2, 32'h11223344, "R7 data write 4B");
    xfer(1, 3'd4, 2'd1, 32'hAABBCCDD, "R7 data write 2B");
    xfer(1, 3'd4, 2'd3, 32'h01020304, "R7 data write size3");
    xfer(1, 3'd4, 2'd0, 32'h000000E7, "R7 data write 1B");
    // R9 direction change
    p0 = dir_pulses;
    xfer(1, 3'd2, 2'd0, 32'h24, "R9 dir to read");
    chk(dir_pulses == p0 + 1, "R9 one pulse", dir_pulses - p0, 1);
    chk(dir_ctl_seen == 8'hC4 && dir_v_seen, "R9 old ctl during pulse",
        {23'h0, dir_v_seen, dir_ctl_seen}, {23'h0, 1'b1, 8'hC4});
    // R3 reads in read pattern
    rd_src = 32'hDEADBEEF;
    xfer(0, 3'd4, 2'd2, 0, "R3 R7 data read 4B");
    xfer(0, 3'd4, 2'd1, 0, "R3 R7 data read 2B");
    xfer(0, 3'd3, 2'd2, 0, "R7 addr read single byte");
    xfer(1, 3'd4, 2'd0, 32'h99, "R2 write blocked in read dir");
    xfer(0, 3'd1, 2'd0, 0, "R6 status no timeout");
    // R8/R4 error mid-access
    err_byte = 1;
    xfer(0, 3'd4, 2'd2, 0, "R8 read stops at error");
    err_byte = -1;
    xfer(0, 3'd1, 2'd0, 0, "R4 R6 status shows timeout");
    xfer(0, 3'd4, 2'd2, 0, "R4 sticky after good read");
    xfer(0, 3'd1, 2'd0, 0, "R4 still set");
    // R5 clear semantics
    xfer(1, 3'd1, 2'd0, 32'hFE, "R5 write bit0 clear");
    xfer(0, 3'd1, 2'd0, 0, "R5 flag kept");
    xfer(1, 3'd1, 2'd0, 32'h01, "R5 write bit0 set");
    xfer(0, 3'd1, 2'd0, 0, "R5 flag cleared");
    // back to write direction, error on first byte
    p0 = dir_pulses;
    xfer(1, 3'd2, 2'd0, 32'h04, "R9 dir to write");
    chk(dir_pulses == p0 + 1 && !dir_v_seen && dir_ctl_seen == 8'hE4, "R9 pulse back",
        {23'h0, dir_v_seen, dir_ctl_seen}, {23'h0, 1'b0, 8'hE4});
    err_byte = 0;
    xfer(1, 3'd4, 2'd1, 32'h00005566, "R8 write stops at first byte");
    err_byte = -1;
    xfer(0, 3'd1, 2'd0, 0, "R4 status after write error");
    // near-miss patterns
    xfer(1, 3'd2, 2'd0, 32'h05, "R10 ctl strobe set");
    xfer(1, 3'd3, 2'd0, 32'h77, "R2 strobe blocks");
    xfer(1, 3'd2, 2'd0, 32'h2C, "R10 ctl select set");
    xfer(0, 3'd4, 2'd2, 0, "R3 select blocks read");
    // other offsets
    xfer(0, 3'd0, 2'd0, 0, "R11 offset0 read");
    xfer(1, 3'd7, 2'd0, 32'h00, "R11 offset7 write");
    xfer(0, 3'd6, 2'd2, 0, "R11 offset6 read");
    p0 = dir_pulses;
    xfer(1, 3'd2, 2'd0, 32'hFFFFFF3F, "R10 ctl upper forced");
    chk(dir_pulses == p0, "R9 no pulse same dir", dir_pulses - p0, 0);
    xfer(0, 3'd2, 2'd0, 0, "R10 ctl readback");
    // R1 reset clears timeout
    xfer(1, 3'd2, 2'd0, 32'h24, "R9 dir for reset test");
    err_byte = 0;
    xfer(0, 3'd3, 2'd0, 0, "R4 addr read error");
    err_byte = -1;
    m_ctl = 8'hCC; m_tmo = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    xfer(0, 3'd1, 2'd0, 0, "R1 timeout cleared by reset");
    xfer(0, 3'd2, 2'd0, 0, "R1 ctl after reset");
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule